// File: doc/BRIEF.md
# Dual-width parallel ROM reader

This block is a synchronous master for an asynchronous parallel ROM whose data bus can be switched between 16-bit words and 8-bit bytes. A host sends a read request with an address and a width flag over a valid/ready stream. The block then runs the ROM pins: chip enable, output enable, width select and the address lines. It waits a number of clock cycles derived from the clock period, samples the data bus and returns the result on a second valid/ready stream. Only one read is outstanding at a time.

In byte mode the ROM's top data pin becomes the least-significant address input. The block therefore drives that pin only in byte mode. A change of width always passes through standby: chip enable goes high, the block waits the output float time, and only then does the width-select pin change. Between reads, output enable is released for a recovery time. After a run of idle cycles the block releases chip enable so the ROM enters standby. The next request then pays the full access time again.

Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a read is in flight and while a result waits unconsumed. A result stays on `rsp_data`, unchanged, with `rsp_valid` high until the edge on which `rsp_ready` is high.

Top module: `prom_rd_ctrl`

## Requirements
- R1: After reset, chip enable and output enable are high (inactive), width select is high (word mode), the top-pin driver is off, `req_ready` is high and `rsp_valid` is low.
- R2: A word request (req_byte=0) drives `rom_a` = `req_addr[22:0]` with chip enable and output enable low from the edge that accepts it. Bit 23 of the request address is ignored. The full 16-bit bus is returned with `rsp_valid` rising ACC_CYC cycles after acceptance.
- R3: ACC_CYC = ceil(T_ACC_PS / CLK_PS), with a minimum of 1. The bus is sampled only after the address and both enables have held steady for ACC_CYC whole cycles.
- R4: A byte request (req_byte=1) drives `rom_a` = `req_addr[23:1]` and puts `req_addr[0]` on `rom_d15_o`. The result is `rom_d_i[7:0]` zero-extended to 16 bits, so bus bits 8 to 15 have no effect.
- R5: Width select (`rom_byte_n`, low = byte) changes only while chip enable has been high for at least one cycle. A request whose width differs from the current one has a latency of ACC_CYC + TURN_CYC + 1 cycles, where TURN_CYC = ceil(T_FLOAT_PS / CLK_PS).
- R6: The top-pin driver `rom_d15_oe` is on only in byte mode. It turns off on the edge that releases chip enable when leaving byte mode. It turns on only after TURN_CYC cycles of chip enable high.
- R7: After sampling, output enable goes high while chip enable stays low, and no new request is taken for TURN_CYC cycles.
- R8: Chip enable is released IDLE_CYC cycles after the block returns to idle with no new request. A request taken from standby again has a latency of ACC_CYC cycles.
- R9: Only one read is outstanding. `req_ready` is low during an access. An unconsumed result holds `rsp_valid` and `rsp_data` stable.
- R10: Output enable is never low while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W+1 | Word address (low ADDR_W bits) or byte address |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid | output | 1 | Read result valid |
| rsp_ready | input | 1 | Host takes the result |
| rsp_data | output | DATA_W | Read result, zero-extended in byte mode |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_byte_n | output | 1 | ROM width select, low = byte mode |
| rom_a | output | ADDR_W | ROM address lines |
| rom_d_i | input | DATA_W | ROM data bus as seen by the block |
| rom_d15_o | output | 1 | Value driven on the top data pin in byte mode |
| rom_d15_oe | output | 1 | Drive enable for the top data pin |

## Verification
Each result has a fixed due cycle, counted from the accepting edge. For a read at the current width, `rsp_valid` is due ACC_CYC edges later (5 at 50 MHz). After a width change it is due ACC_CYC + TURN_CYC + 1 edges later (7). Chip enable rises IDLE_CYC edges after the block re-enters idle, and `req_ready` returns TURN_CYC edges after the sample. The bench drives and samples on falling edges and counts them from the accepting edge, so each check lands exactly on its due cycle. Its ROM model returns junk until the pins have held steady long enough, so an early sample shows up as wrong data.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_LAUNCH,
    ST_ACCESS,
    ST_TURN
  } rd_state_e;

  // whole clock cycles needed to cover a delay, never less than one
  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned r;
    r = (t_ps + clk_ps - 1) / clk_ps;
    return (r < 1) ? 1 : r;
  endfunction

endpackage

// File: rtl/prom_wait_cnt.sv
module prom_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/prom_rsp_buf.sv
module prom_rsp_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] d_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] lane_data;

  // byte mode: only the low lane carries data, the rest is floating
  always_comb begin
    lane_data = d_in;
    if (byte_sel) lane_data = {{(DATA_W-LANE_W){1'b0}}, d_in[LANE_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (capture) begin
      rsp_valid <= 1'b1;
      rsp_data  <= lane_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/prom_rd_fsm.sv
module prom_rd_fsm
  import prom_rd_pkg::*;
#(
  parameter int          ADDR_W   = 23,
  parameter int          PH_W     = 3,
  parameter int unsigned ACC_CYC  = 5,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [ADDR_W:0] req_addr,
  input  logic            req_byte,
  input  logic            rsp_busy,
  input  logic            ph_zero,
  input  logic            idle_zero,
  output logic            ph_load,
  output logic [PH_W-1:0] ph_val,
  output logic            idle_load,
  output logic            capture,
  output logic            byte_sel,
  output logic            rom_ce_n,
  output logic            rom_oe_n,
  output logic            rom_byte_n,
  output logic [ADDR_W-1:0] rom_a,
  output logic            rom_d15_o,
  output logic            rom_d15_oe
);

  localparam logic [PH_W-1:0] ACC_LD  = PH_W'(ACC_CYC - 1);
  localparam logic [PH_W-1:0] TURN_LD = PH_W'(TURN_CYC - 1);

  rd_state_e       state_q;
  logic [ADDR_W:0] pend_addr_q;
  logic            pend_byte_q;
  logic            accept;
  logic            width_change;

  assign req_ready    = (state_q == ST_IDLE) && !rsp_busy;
  assign accept       = req_valid && req_ready;
  assign width_change = (req_byte == rom_byte_n);
  assign byte_sel     = !rom_byte_n;

  always_comb begin
    ph_load   = 1'b0;
    ph_val    = '0;
    idle_load = 1'b0;
    capture   = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        ph_load = 1'b1;
        ph_val  = width_change ? TURN_LD : ACC_LD;
      end
      ST_LAUNCH: begin
        ph_load = 1'b1;
        ph_val  = ACC_LD;
      end
      ST_ACCESS: if (ph_zero) begin
        capture = 1'b1;
        ph_load = 1'b1;
        ph_val  = TURN_LD;
      end
      ST_TURN: if (ph_zero) idle_load = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rom_ce_n    <= 1'b1;
      rom_oe_n    <= 1'b1;
      rom_byte_n  <= 1'b1;
      rom_a       <= '0;
      rom_d15_o   <= 1'b0;
      rom_d15_oe  <= 1'b0;
      pend_addr_q <= '0;
      pend_byte_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            pend_addr_q <= req_addr;
            pend_byte_q <= req_byte;
            if (width_change) begin
              // park in standby so the width pin can move safely
              state_q    <= ST_SWITCH;
              rom_ce_n   <= 1'b1;
              rom_oe_n   <= 1'b1;
              rom_d15_oe <= 1'b0;
            end else begin
              state_q  <= ST_ACCESS;
              rom_ce_n <= 1'b0;
              rom_oe_n <= 1'b0;
              if (req_byte) begin
                rom_a     <= req_addr[ADDR_W:1];
                rom_d15_o <= req_addr[0];
              end else begin
                rom_a <= req_addr[ADDR_W-1:0];
              end
            end
          end else if (!rom_ce_n && idle_zero) begin
            rom_ce_n <= 1'b1;
          end
        end
        ST_SWITCH: if (ph_zero) begin
          rom_byte_n <= !pend_byte_q;
          rom_d15_oe <= pend_byte_q;
          state_q    <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          state_q  <= ST_ACCESS;
          rom_ce_n <= 1'b0;
          rom_oe_n <= 1'b0;
          if (pend_byte_q) begin
            rom_a     <= pend_addr_q[ADDR_W:1];
            rom_d15_o <= pend_addr_q[0];
          end else begin
            rom_a <= pend_addr_q[ADDR_W-1:0];
          end
        end
        ST_ACCESS: if (ph_zero) begin
          rom_oe_n <= 1'b1;
          state_q  <= ST_TURN;
        end
        ST_TURN: if (ph_zero) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int          ADDR_W     = 23,
  parameter int          DATA_W     = 16,
  parameter int unsigned CLK_PS     = 20000,
  parameter int unsigned T_ACC_PS   = 90000,
  parameter int unsigned T_FLOAT_PS = 20000,
  parameter int unsigned IDLE_CYC   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W:0]   req_addr,
  input  logic              req_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rom_ce_n,
  output logic              rom_oe_n,
  output logic              rom_byte_n,
  output logic [ADDR_W-1:0] rom_a,
  input  logic [DATA_W-1:0] rom_d_i,
  output logic              rom_d15_o,
  output logic              rom_d15_oe
);

  localparam int unsigned ACC_CYC  = cyc_ceil(T_ACC_PS, CLK_PS);
  localparam int unsigned TURN_CYC = cyc_ceil(T_FLOAT_PS, CLK_PS);
  localparam int unsigned PH_MAX   = (ACC_CYC > TURN_CYC) ? ACC_CYC : TURN_CYC;
  localparam int          PH_W     = $clog2(PH_MAX + 1);
  localparam int unsigned IDLE_MIN = (IDLE_CYC < 1) ? 1 : IDLE_CYC;
  localparam int          IDLE_W   = $clog2(IDLE_MIN + 1);

  logic            ph_load, ph_zero, idle_load, idle_zero, capture, byte_sel;
  logic [PH_W-1:0] ph_val;

  prom_rd_fsm #(
    .ADDR_W  (ADDR_W),
    .PH_W    (PH_W),
    .ACC_CYC (ACC_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_byte  (req_byte),
    .rsp_busy  (rsp_valid),
    .ph_zero   (ph_zero),
    .idle_zero (idle_zero),
    .ph_load   (ph_load),
    .ph_val    (ph_val),
    .idle_load (idle_load),
    .capture   (capture),
    .byte_sel  (byte_sel),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .rom_byte_n(rom_byte_n),
    .rom_a     (rom_a),
    .rom_d15_o (rom_d15_o),
    .rom_d15_oe(rom_d15_oe)
  );

  prom_wait_cnt #(.W(PH_W)) u_phase_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ph_load),
    .load_val(ph_val),
    .zero    (ph_zero)
  );

  prom_wait_cnt #(.W(IDLE_W)) u_idle_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (idle_load),
    .load_val(IDLE_W'(IDLE_MIN - 1)),
    .zero    (idle_zero)
  );

  prom_rsp_buf #(.DATA_W(DATA_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .byte_sel (byte_sel),
    .d_in     (rom_d_i),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

endmodule

// File: rtl/prom_rd_chk.sv
module prom_rd_chk
  import prom_rd_pkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int unsigned CLK_PS   = 20000,
  parameter int unsigned T_ACC_PS = 90000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rom_ce_n,
  input logic              rom_oe_n,
  input logic              rom_byte_n,
  input logic              rom_d15_oe
);

  localparam int unsigned ACC_CYC = cyc_ceil(T_ACC_PS, CLK_PS);
  localparam int          OW      = $clog2(ACC_CYC + 2);

  logic [OW-1:0] oe_low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || rom_oe_n)              oe_low_cnt <= '0;
    else if (oe_low_cnt != OW'(ACC_CYC + 1)) oe_low_cnt <= oe_low_cnt + 1'b1;
  end

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !rom_ce_n); // R10
  AST_WIDTH_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_byte_n) |-> (rom_ce_n && $past(rom_ce_n))); // R5
  AST_D15_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rom_d15_oe |-> !rom_byte_n); // R6
  AST_D15_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_d15_oe) |-> $past(rom_ce_n)); // R6
  AST_ACCESS_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (oe_low_cnt >= OW'(ACC_CYC))); // R3
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (rom_oe_n && !rom_ce_n)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R9
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_oe_n |-> !req_ready); // R9

endmodule

bind prom_rd_ctrl prom_rd_chk #(
  .DATA_W  (DATA_W),
  .CLK_PS  (CLK_PS),
  .T_ACC_PS(T_ACC_PS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rom_ce_n  (rom_ce_n),
  .rom_oe_n  (rom_oe_n),
  .rom_byte_n(rom_byte_n),
  .rom_d15_oe(rom_d15_oe)
);

// File: tb/prom_rd_ctrl_tb.sv
`timescale 1ns/1ps
module prom_rd_ctrl_tb;

  localparam int ACC  = 5;   // ceil(90/20)
  localparam int TURN = 1;   // ceil(20/20)
  localparam int IDLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic        rom_ce_n, rom_oe_n, rom_byte_n, rom_d15_o, rom_d15_oe;
  logic [22:0] rom_a;
  logic [15:0] rom_d_i;

  int total = 0;
  int failed = 0;

  always #10 clk = ~clk;

  prom_rd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_byte(req_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_byte_n(rom_byte_n), .rom_a(rom_a),
    .rom_d_i(rom_d_i), .rom_d15_o(rom_d15_o), .rom_d15_oe(rom_d15_oe)
  );

  // ROM model: data only after the pins held steady long enough
  function automatic logic [15:0] word_of(input logic [22:0] a);
    return a[15:0] ^ {a[22:16], 9'h1A5} ^ 16'h3C96;
  endfunction

  logic [26:0] key, key_q = '1;
  int age = 0;
  assign key = {rom_ce_n, rom_oe_n, rom_byte_n, rom_a, rom_d15_oe ? rom_d15_o : 1'b0};

  always @(negedge clk) begin
    if (key != key_q) age <= 0;
    else if (age < 1000) age <= age + 1;
    key_q <= key;
  end

  always_comb begin
    logic [15:0] w;
    w = word_of(rom_a);
    if (rom_ce_n || rom_oe_n)   rom_d_i = 16'hEEEE;
    else if (age < ACC - 1)     rom_d_i = 16'hBAD0;
    else if (!rom_byte_n)
      rom_d_i = {rom_d15_oe ? rom_d15_o : 1'b1, 7'h55, rom_d15_o ? w[15:8] : w[7:0]};
    else                        rom_d_i = w;
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_byte(input logic [23:0] ba);
    logic [15:0] w;
    w = word_of(ba[23:1]);
    return ba[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  // one read; called at a falling edge, returns at a falling edge
  task automatic do_read(input logic [23:0] addr, input logic bmode, input bit consume,
                         output int lat, output logic [15:0] data,
                         output logic [22:0] a_s, output logic d15_s, output logic d15oe_s,
                         output logic bn_s, output logic n0_ce, output logic n0_d15oe,
                         output logic oe_r, output logic ce_r, output logic rdy_r);
    chk(req_ready == 1'b1, "R9 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_byte = bmode;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    n0_ce = rom_ce_n; n0_d15oe = rom_d15_oe;
    lat = 0;
    a_s = rom_a; d15_s = rom_d15_o; d15oe_s = rom_d15_oe; bn_s = rom_byte_n;
    while (!rsp_valid && lat < 100) begin
      a_s = rom_a; d15_s = rom_d15_o; d15oe_s = rom_d15_oe; bn_s = rom_byte_n;
      @(negedge clk);
      lat++;
    end
    data = rsp_data; oe_r = rom_oe_n; ce_r = rom_ce_n; rdy_r = req_ready;
    if (consume) begin
      rsp_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      rsp_ready = 1'b0;
    end
  endtask

  int lat;
  logic [15:0] data;
  logic [22:0] a_s;
  logic d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r;

  task automatic t_reset();
    chk(rom_ce_n == 1'b1,   "R1 ce_n", rom_ce_n, 1);
    chk(rom_oe_n == 1'b1,   "R1 oe_n", rom_oe_n, 1);
    chk(rom_byte_n == 1'b1, "R1 byte_n", rom_byte_n, 1);
    chk(rom_d15_oe == 1'b0, "R1 d15_oe", rom_d15_oe, 0);
    chk(req_ready == 1'b1,  "R1 req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0,  "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_word();
    do_read(24'h80_1234, 1'b0, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    chk(lat == ACC, "R2 word latency", lat, ACC);
    chk(a_s == 23'h001234, "R2 address, bit 23 ignored", a_s, 23'h001234);
    chk(data == word_of(23'h001234), "R3 word data after access time", data, word_of(23'h001234));
    chk(bn_s == 1'b1, "R2 width select word", bn_s, 1);
    do_read(24'h7F_FFFF, 1'b0, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    chk(lat == ACC, "R2 second word latency", lat, ACC);
    chk(data == word_of(23'h7FFFFF), "R2 top word data", data, word_of(23'h7FFFFF));
    chk(oe_r == 1'b1 && ce_r == 1'b0, "R7 oe released, ce held", {oe_r, ce_r}, 2'b10);
    chk(rdy_r == 1'b0, "R7 no request during recovery", rdy_r, 0);
  endtask

  task automatic t_backpressure();
    logic [15:0] first;
    do_read(24'h00_0042, 1'b0, 1'b0, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    first = data;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R9 valid held", rsp_valid, 1);
      chk(rsp_data == first, "R9 data held", rsp_data, first);
      chk(req_ready == 1'b0, "R9 one outstanding", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R9 consumed", rsp_valid, 0);
  endtask

  task automatic t_byte();
    do_read(24'h00_0ABD, 1'b1, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    chk(n0_ce == 1'b1, "R5 standby before width change", n0_ce, 1);
    chk(lat == ACC + TURN + 1, "R5 width change latency", lat, ACC + TURN + 1);
    chk(a_s == 23'h00055E && d15_s == 1'b1, "R4 byte address split", {a_s, d15_s}, {23'h00055E, 1'b1});
    chk(d15oe_s == 1'b1 && bn_s == 1'b0, "R6 top pin driven in byte mode", {d15oe_s, bn_s}, 2'b10);
    chk(data == exp_byte(24'h00_0ABD), "R4 odd byte zero-extended", data, exp_byte(24'h00_0ABD));
    do_read(24'hFF_FFFE, 1'b1, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    chk(lat == ACC, "R4 byte latency same width", lat, ACC);
    chk(a_s == 23'h7FFFFF && d15_s == 1'b0, "R4 even byte address", {a_s, d15_s}, {23'h7FFFFF, 1'b0});
    chk(data == exp_byte(24'hFF_FFFE), "R4 upper lane ignored", data, exp_byte(24'hFF_FFFE));
  endtask

  task automatic t_word_again();
    do_read(24'h00_3210, 1'b0, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    chk(n0_d15oe == 1'b0 && n0_ce == 1'b1, "R6 driver off with ce release", {n0_d15oe, n0_ce}, 2'b01);
    chk(lat == ACC + TURN + 1, "R5 back to word latency", lat, ACC + TURN + 1);
    chk(d15oe_s == 1'b0 && bn_s == 1'b1, "R6 no drive in word mode", {d15oe_s, bn_s}, 2'b01);
    chk(data == word_of(23'h003210), "R2 word data after switch", data, word_of(23'h003210));
  endtask

  task automatic t_standby();
    do_read(24'h00_0777, 1'b0, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    // now one falling edge after the response: TURN edges into recovery
    for (int i = 1; i < TURN; i++) @(negedge clk);
    for (int i = 0; i < IDLE - 1; i++) @(negedge clk);
    chk(rom_ce_n == 1'b0, "R8 ce held before timeout", rom_ce_n, 0);
    @(negedge clk);
    chk(rom_ce_n == 1'b1, "R8 standby after idle cycles", rom_ce_n, 1);
    do_read(24'h00_1ACE, 1'b0, 1'b1, lat, data, a_s, d15_s, d15oe_s, bn_s, n0_ce, n0_d15oe, oe_r, ce_r, rdy_r);
    chk(n0_ce == 1'b0, "R8 ce reasserted on request", n0_ce, 0);
    chk(lat == ACC, "R8 full access from standby", lat, ACC);
    chk(data == word_of(23'h001ACE), "R8 data from standby", data, word_of(23'h001ACE));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_backpressure();
    t_byte();
    t_word_again();
    t_standby();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++;
    failed++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule